// File: doc/BRIEF.md
# I2C Register-File Slave for a Cell-Monitor Front End

This block is the serial control port of a battery-monitor front end. An external controller reaches it over a two-wire I2C bus and uses it to read a small set of status bytes and to program the configuration bytes that steer the rest of the chip: the analog output selector with its user flags, the sleep control, the feature-set byte and the write-key byte. The configuration bytes leave the block on parallel output buses. Three event inputs feed the status bytes: the external and internal over-temperature conditions, and the qualified level of the wake pin.

SCL and SDA enter through a two-flop synchronizer and a stability filter. The filtered lines drive an enumerated bus state machine with these states: ST_IDLE, ST_DEV, ST_DEV_ACK, ST_PTR, ST_PTR_ACK, ST_WR, ST_WR_ACK, ST_RD and ST_RD_ACK. A STOP from any state goes to ST_IDLE, and a START or repeated START from any state goes to ST_DEV. ST_DEV moves to ST_DEV_ACK after eight bits that match the address, and to ST_IDLE after eight bits that do not. ST_DEV_ACK moves to ST_RD for a read and to ST_PTR for a write. ST_PTR goes to ST_PTR_ACK and then to ST_WR. ST_WR and ST_WR_ACK alternate, one pass per data byte. ST_RD moves to ST_RD_ACK after eight bits. ST_RD_ACK returns to ST_RD when the controller acknowledges and to ST_IDLE when it does not. Every transition except START and STOP happens on a filtered SCL falling edge, so the SDA drive only changes while SCL is low.

A register pointer chooses the byte that each data phase touches. It is loaded by the second byte of a write, advances after every byte written or read, and returns to 0x00 after 0x0A.

Top module: `afe_i2c_regfile`

## Requirements
- R1: The block answers only to the 7-bit address 0x28 (address byte 0x50 to write, 0x51 to read). It acknowledges a matching address byte by pulling SDA low for the ninth clock. A byte with any other address is not acknowledged, and the bytes after it up to the next START have no effect.
- R2: A write is the address byte, then a pointer byte, then data bytes, each one acknowledged. A data byte is stored on the SCL falling edge after its eighth bit, and the pointer then advances by one. Bytes are sent MSB first.
- R3: When the pointer advances from 0x0A it becomes 0x00. This applies to both writes and reads.
- R4: A random read is a write of only the pointer byte, a repeated START, then 0x51. The block shifts out the addressed byte MSB first, one bit for each SCL, and advances the pointer after each byte. After the controller's NACK it releases SDA and sends nothing more.
- R5: A current-address read (0x51 straight after START) returns the byte at the pointer left by the last access.
- R6: Address 0x07 (feature byte, output feat_q) takes a write only while bit 7 of address 0x08 (wen_q) is 1. After reset that bit is 0.
- R7: At address 0x01, bit 5 latches the external over-temperature input and bit 4 latches the internal one. Reading 0x01 clears a latched bit only if its input is low at that moment.
- R8: Address 0x00 reads with bit 5 always 1 and bit 4 equal to wake_lvl_i. Its other bits read 0.
- R9: Only these bits can be written: mask 0xCF at 0x03 (amux_q), 0x80 at 0x04 (ctrl_q), 0xE7 at 0x07 and 0x98 at 0x08. All other bits read as 0. Addresses 0x00 and 0x01 are read-only.
- R10: Writes to 0x02, 0x05, 0x06 and to 0x09 and above are acknowledged and thrown away. Reads of those addresses return 0x00.
- R11: sda_oe changes only while SCL is low. A STOP sends the block to idle with SDA released.
- R12: After reset every writable byte is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ext_hot_i | input | 1 | External over-temperature condition |
| int_hot_i | input | 1 | Internal over-temperature condition |
| wake_lvl_i | input | 1 | Qualified wake-pin level |
| amux_q | output | 8 | Byte 0x03: user flags and analog selector |
| ctrl_q | output | 8 | Byte 0x04: sleep control |
| feat_q | output | 8 | Byte 0x07: feature set |
| wen_q | output | 8 | Byte 0x08: write key and user flags |

## Verification
The hardest case to reach is a latched over-temperature bit being read while its input is still high. The bit must then survive the read, and only a later read after the input has dropped may clear it. The stimulus holds the internal input high across two complete repeated-START reads of 0x01, then lowers it and reads twice more. The external input is pulsed between transactions, so its latch is exercised with the input already low. Pointer wrap is reached through a six-byte burst that starts at 0x09 and ends in 0x03, and through a four-byte read that starts at 0x08 and continues across 0x0A into the identity byte.

// File: rtl/afe_i2c_pkg.sv
package afe_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_state_t;

    localparam logic [7:0] A_ID   = 8'h00;
    localparam logic [7:0] A_STAT = 8'h01;
    localparam logic [7:0] A_AMUX = 8'h03;
    localparam logic [7:0] A_CTRL = 8'h04;
    localparam logic [7:0] A_FEAT = 8'h07;
    localparam logic [7:0] A_WEN  = 8'h08;

    localparam logic [7:0] MASK_AMUX = 8'hCF;
    localparam logic [7:0] MASK_CTRL = 8'h80;
    localparam logic [7:0] MASK_FEAT = 8'hE7;
    localparam logic [7:0] MASK_WEN  = 8'h98;

    localparam int KEY_BIT  = 7;
    localparam int XOT_BIT  = 5;
    localparam int IOT_BIT  = 4;
    localparam int ID_BIT   = 5;
    localparam int WAKE_BIT = 4;

endpackage

// File: rtl/afe_i2c_deglitch.sv
module afe_i2c_deglitch #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE + 1);

    logic [1:0]    sync;
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync <= 2'b11;
            dout <= 1'b1;
            run  <= '0;
        end else begin
            sync <= {sync[0], din};
            if (sync[1] == dout) begin
                run <= '0;
            end else if (run == CW'(STABLE - 1)) begin
                dout <= sync[1];
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/afe_i2c_engine.sv
module afe_i2c_engine
    import afe_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h28,
    parameter logic [7:0] LAST_REG = 8'h0A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] rd_data,
    output logic [7:0] reg_ptr,
    output logic       rd_stb,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    bus_state_t state, state_n;
    logic       scl_d, sda_d;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [7:0] tx;
    logic       rw;
    logic       nack;

    logic start_ev, stop_ev, rise, fall, rx_phase, byte_done;
    logic [7:0] ptr_next;

    assign start_ev  = scl_f && scl_d && sda_d && !sda_f;
    assign stop_ev   = scl_f && scl_d && !sda_d && sda_f;
    assign rise      = scl_f && !scl_d;
    assign fall      = !scl_f && scl_d;
    assign rx_phase  = (state == ST_DEV) || (state == ST_PTR) || (state == ST_WR);
    assign byte_done = fall && (cnt == 4'd8);
    assign ptr_next  = (reg_ptr == LAST_REG) ? 8'h00 : reg_ptr + 8'h01;

    // next-state logic
    always_comb begin
        state_n = state;
        if (stop_ev) begin
            state_n = ST_IDLE;
        end else if (start_ev) begin
            state_n = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:    state_n = ST_IDLE;
                ST_DEV:     if (byte_done)
                                state_n = (sh[7:1] == DEV_ADDR) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (fall) state_n = rw ? ST_RD : ST_PTR;
                ST_PTR:     if (byte_done) state_n = ST_PTR_ACK;
                ST_PTR_ACK: if (fall) state_n = ST_WR;
                ST_WR:      if (byte_done) state_n = ST_WR_ACK;
                ST_WR_ACK:  if (fall) state_n = ST_WR;
                ST_RD:      if (fall && cnt == 4'd7) state_n = ST_RD_ACK;
                ST_RD_ACK:  if (fall) state_n = nack ? ST_IDLE : ST_RD;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    assign rd_stb  = fall && !stop_ev && !start_ev &&
                     (((state == ST_DEV_ACK) && rw) || ((state == ST_RD_ACK) && !nack));
    assign wr_stb  = (state == ST_WR) && byte_done;
    assign wr_data = sh;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            reg_ptr <= '0;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            if (start_ev || (state_n != state)) begin
                cnt <= '0;
            end else if (rx_phase && rise) begin
                cnt <= cnt + 4'd1;
            end else if ((state == ST_RD) && fall) begin
                cnt <= cnt + 4'd1;
            end
            if (rx_phase && rise) sh <= {sh[6:0], sda_f};
            if ((state == ST_DEV) && byte_done) rw <= sh[0];
            if ((state == ST_RD_ACK) && rise) nack <= sda_f;
            if ((state == ST_PTR) && byte_done) begin
                reg_ptr <= sh;
            end else if (rd_stb || wr_stb) begin
                reg_ptr <= ptr_next;
            end
            if (rd_stb) begin
                tx <= rd_data;
            end else if ((state == ST_RD) && fall && (cnt != 4'd7)) begin
                tx <= {tx[6:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                             sda_oe = !tx[7];
            default:                           sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/afe_i2c_bank.sv
module afe_i2c_bank
    import afe_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       ext_hot_i,
    input  logic       int_hot_i,
    input  logic       wake_lvl_i,
    output logic [7:0] rd_data,
    output logic [7:0] amux_q,
    output logic [7:0] ctrl_q,
    output logic [7:0] feat_q,
    output logic [7:0] wen_q,
    output logic       xot_q,
    output logic       iot_q
);
    logic stat_read;
    assign stat_read = rd_stb && (addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amux_q <= '0;
            ctrl_q <= '0;
            feat_q <= '0;
            wen_q  <= '0;
        end else if (wr_stb) begin
            unique case (addr)
                A_AMUX:  amux_q <= wr_data & MASK_AMUX;
                A_CTRL:  ctrl_q <= wr_data & MASK_CTRL;
                A_FEAT:  if (wen_q[KEY_BIT]) feat_q <= wr_data & MASK_FEAT;
                A_WEN:   wen_q  <= wr_data & MASK_WEN;
                default: ;
            endcase
        end
    end

    // sticky status: set by condition, cleared by a read once condition is gone
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xot_q <= 1'b0;
            iot_q <= 1'b0;
        end else begin
            xot_q <= ext_hot_i || (xot_q && !stat_read);
            iot_q <= int_hot_i || (iot_q && !stat_read);
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_ID: begin
                rd_data[ID_BIT]   = 1'b1;
                rd_data[WAKE_BIT] = wake_lvl_i;
            end
            A_STAT: begin
                rd_data[XOT_BIT] = xot_q;
                rd_data[IOT_BIT] = iot_q;
            end
            A_AMUX:  rd_data = amux_q;
            A_CTRL:  rd_data = ctrl_q;
            A_FEAT:  rd_data = feat_q;
            A_WEN:   rd_data = wen_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/afe_i2c_regfile.sv
module afe_i2c_regfile #(
    parameter logic [6:0] DEV_ADDR = 7'h28,
    parameter logic [7:0] LAST_REG = 8'h0A,
    parameter int         FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       ext_hot_i,
    input  logic       int_hot_i,
    input  logic       wake_lvl_i,
    output logic [7:0] amux_q,
    output logic [7:0] ctrl_q,
    output logic [7:0] feat_q,
    output logic [7:0] wen_q
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw, line_f;
    logic [7:0] reg_ptr, rd_data, wr_data;
    logic       rd_stb, wr_stb;
    logic       xot_q, iot_q;

    assign line_raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        afe_i2c_deglitch #(.STABLE(FILT_LEN)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[g]),
            .dout (line_f[g])
        );
    end

    afe_i2c_engine #(.DEV_ADDR(DEV_ADDR), .LAST_REG(LAST_REG)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_f  (line_f[0]),
        .sda_f  (line_f[1]),
        .rd_data(rd_data),
        .reg_ptr(reg_ptr),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .wr_data(wr_data),
        .sda_oe (sda_oe)
    );

    afe_i2c_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_ptr),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .ext_hot_i (ext_hot_i),
        .int_hot_i (int_hot_i),
        .wake_lvl_i(wake_lvl_i),
        .rd_data   (rd_data),
        .amux_q    (amux_q),
        .ctrl_q    (ctrl_q),
        .feat_q    (feat_q),
        .wen_q     (wen_q),
        .xot_q     (xot_q),
        .iot_q     (iot_q)
    );
endmodule

// File: rtl/afe_i2c_regfile_chk.sv
module afe_i2c_regfile_chk
    import afe_i2c_pkg::*;
#(
    parameter logic [7:0] LAST_REG = 8'h0A
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_oe,
    input logic [7:0] feat_q,
    input logic [7:0] wen_q,
    input logic       ext_hot_i,
    input logic       xot_q,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [7:0] reg_ptr,
    input bus_state_t state
);
    // R11: the SDA drive moves only while the raw clock is low
    a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    // R11: nothing is driven while idle
    a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R6: the feature byte changes only when the key bit was set
    a_r6_feat_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(feat_q) |-> $past(wen_q[KEY_BIT]));

    // R7: an active condition is latched on the next cycle
    a_r7_xot_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hot_i |=> xot_q);

    // R7: the latch drops only through a status read with the condition gone
    a_r7_xot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xot_q) |-> $past(rd_stb && (reg_ptr == A_STAT) && !ext_hot_i));

    // R3: pointer wraps after the last address
    a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && (reg_ptr == LAST_REG)) |=> (reg_ptr == 8'h00));

    // R4: the controller owns SDA during its acknowledge slot
    a_r4_rd_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_oe);
endmodule

bind afe_i2c_regfile afe_i2c_regfile_chk #(.LAST_REG(LAST_REG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .feat_q   (feat_q),
    .wen_q    (wen_q),
    .ext_hot_i(ext_hot_i),
    .xot_q    (xot_q),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .reg_ptr  (reg_ptr),
    .state    (u_eng.state)
);

// File: tb/tb_afe_i2c_regfile.sv
module tb_afe_i2c_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 16;
    localparam int Q  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic ext_hot = 1'b0, int_hot = 1'b0, wake = 1'b0;
    logic sda_oe, sda_line;
    logic [7:0] amux_q, ctrl_q, feat_q, wen_q;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    afe_i2c_regfile dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .ext_hot_i(ext_hot), .int_hot_i(int_hot), .wake_lvl_i(wake),
        .amux_q(amux_q), .ctrl_q(ctrl_q), .feat_q(feat_q), .wen_q(wen_q)
    );

    int nchk = 0, nerr = 0;
    int since_edge = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    // behavioural reference model
    logic [7:0] m3 = 0, m4 = 0, m7 = 0, m8 = 0;
    logic [7:0] mptr = 0;
    logic       xot_m = 0, iot_m = 0;
    logic [7:0] wq[$];

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ptr_inc(input logic [7:0] p);
        return (p == 8'h0A) ? 8'h00 : p + 8'h01;
    endfunction

    task automatic model_write(input logic [7:0] b);
        case (mptr)
            8'h03: m3 = b & 8'hCF;
            8'h04: m4 = b & 8'h80;
            8'h07: if (m8[7]) m7 = b & 8'hE7;
            8'h08: m8 = b & 8'h98;
            default: ;
        endcase
        mptr = ptr_inc(mptr);
    endtask

    task automatic model_read(output logic [7:0] v);
        case (mptr)
            8'h00: v = {2'b00, 1'b1, wake, 4'h0};
            8'h01: begin
                v = {2'b00, xot_m, iot_m, 4'h0};
                xot_m = ext_hot;
                iot_m = int_hot;
            end
            8'h03: v = m3;
            8'h04: v = m4;
            8'h07: v = m7;
            8'h08: v = m8;
            default: v = 8'h00;
        endcase
        mptr = ptr_inc(mptr);
    endtask

    // per-clock comparison of the configuration outputs
    always @(negedge clk) begin
        if (run_cmp) begin
            since_edge++;
            if (since_edge > 10) begin
                chk("R2/R6/R9 amux_q", amux_q, m3);
                chk("R2/R9 ctrl_q", ctrl_q, m4);
                chk("R6/R9 feat_q", feat_q, m7);
                chk("R6/R9 wen_q", wen_q, m8);
            end
        end
    end

    task automatic set_scl(input logic v);
        scl_m = v;
        since_edge = 0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HP);
        set_scl(1'b1); tick(HP);
        sda_m = 1'b0; tick(HP);
        set_scl(1'b0); tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        set_scl(1'b1); tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    // mode 0: address byte, 1: pointer byte, 2: data byte
    task automatic send_byte(input logic [7:0] b, input int mode, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HP);
            set_scl(1'b1); tick(HP);
            set_scl(1'b0);
            if (i == 0 && mode == 1) mptr = b;
            if (i == 0 && mode == 2) model_write(b);
            tick(Q);
        end
        sda_m = 1'b1; tick(HP - Q);
        set_scl(1'b1); tick(HP / 2);
        acked = !sda_line;
        tick(HP / 2);
        set_scl(1'b0); tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HP);
            set_scl(1'b1); tick(HP / 2);
            b[i] = sda_line;
            tick(HP / 2);
            set_scl(1'b0);
        end
        tick(Q);
        sda_m = mack ? 1'b0 : 1'b1;
        tick(HP - Q);
        set_scl(1'b1); tick(HP);
        set_scl(1'b0); tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic wr_burst(input logic [7:0] p, input string tag);
        logic ack;
        bus_start();
        send_byte(8'h50, 0, ack); chk({tag, " R1 address ack"}, ack, 1);
        send_byte(p, 1, ack);     chk({tag, " R2 pointer ack"}, ack, 1);
        foreach (wq[k]) begin
            send_byte(wq[k], 2, ack); chk({tag, " R2 data ack"}, ack, 1);
        end
        bus_stop();
        tick(4);
        chk({tag, " R11 idle release"}, sda_oe, 0);
    endtask

    task automatic rd_words(input int n, input string tag);
        logic [7:0] got, exp;
        for (int k = 0; k < n; k++) begin
            model_read(exp);
            recv_byte(k != n - 1, got);
            chk({tag, " R4 read data"}, got, exp);
        end
        tick(6);
        chk({tag, " R4 release after nack"}, sda_oe, 0);
        bus_stop();
    endtask

    task automatic rd_burst(input logic [7:0] p, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(8'h50, 0, ack); chk({tag, " R1 ack"}, ack, 1);
        send_byte(p, 1, ack);     chk({tag, " R4 pointer ack"}, ack, 1);
        bus_start();
        send_byte(8'h51, 0, ack); chk({tag, " R4 read ack"}, ack, 1);
        rd_words(n, tag);
    endtask

    task automatic cur_rd(input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(8'h51, 0, ack); chk({tag, " R5 ack"}, ack, 1);
        rd_words(n, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic ack;
        tick(5);
        // R12: reset state
        chk("R12 amux reset", amux_q, 0);
        chk("R12 ctrl reset", ctrl_q, 0);
        chk("R12 feat reset", feat_q, 0);
        chk("R12 wen reset", wen_q, 0);
        chk("R12 sda released", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);
        run_cmp = 1'b1;

        // R2 R9: single write with reserved bits masked
        wq = {8'hFF};
        wr_burst(8'h03, "R2 R9 single");
        chk("R9 amux mask", amux_q, 8'hCF);
        // R2: burst with auto-increment
        wq = {8'h41, 8'hFF};
        wr_burst(8'h03, "R2 burst");
        chk("R2 amux burst", amux_q, 8'h41);
        chk("R2 ctrl burst", ctrl_q, 8'h80);

        // R6: feature byte locked, then unlocked
        wq = {8'hFF};
        wr_burst(8'h07, "R6 locked");
        chk("R6 locked write ignored", feat_q, 8'h00);
        wq = {8'hFF};
        wr_burst(8'h08, "R6 key");
        chk("R9 wen mask", wen_q, 8'h98);
        wq = {8'hFF};
        wr_burst(8'h07, "R6 open");
        chk("R6 open write", feat_q, 8'hE7);
        wq = {8'h00};
        wr_burst(8'h08, "R6 relock");
        wq = {8'h00};
        wr_burst(8'h07, "R6 relocked");
        chk("R6 relocked write ignored", feat_q, 8'hE7);

        // R1: foreign address is not acknowledged and bytes after it do nothing
        bus_start();
        send_byte(8'h30, 0, ack); chk("R1 foreign address nack", ack, 0);
        send_byte(8'h03, 0, ack); chk("R1 ignored byte nack", ack, 0);
        send_byte(8'h00, 0, ack); chk("R1 ignored data nack", ack, 0);
        bus_stop();
        tick(12);
        chk("R1 amux untouched", amux_q, 8'h41);

        // R3 R10: burst from 0x09 across the wrap into 0x03
        wq = {8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'h12};
        wr_burst(8'h09, "R3 R10 wrap write");
        chk("R3 wrap lands on amux", amux_q, 8'h02);

        // R10: unused address reads zero; R8 identity and wake level
        rd_burst(8'h02, 1, "R10 unused read");
        wake = 1'b1;
        rd_burst(8'h00, 1, "R8 wake high");
        wake = 1'b0;
        rd_burst(8'h00, 1, "R8 wake low");

        // R3 R4 R10: multi-byte read across the wrap, then R5 current address
        rd_burst(8'h08, 4, "R3 R4 wrap read");
        cur_rd(1, "R5 current address");
        cur_rd(2, "R5 current address burst");

        // R7: pulsed external condition cleared by read
        ext_hot = 1'b1; tick(6); ext_hot = 1'b0; xot_m = 1'b1; tick(6);
        rd_burst(8'h01, 1, "R7 xot latched");
        rd_burst(8'h01, 1, "R7 xot cleared");
        // R7: internal condition held across reads
        int_hot = 1'b1; iot_m = 1'b1; tick(6);
        rd_burst(8'h01, 1, "R7 iot active");
        rd_burst(8'h01, 1, "R7 iot held");
        int_hot = 1'b0; tick(6);
        rd_burst(8'h01, 1, "R7 iot after drop");
        rd_burst(8'h01, 1, "R7 iot cleared");

        tick(20);
        chk("R11 idle release end", sda_oe, 0);
        run_cmp = 1'b0;
        finish_run();
    end
endmodule